// File: doc/BRIEF.md
# Legacy Interrupt Status and Enable Controller

This block collects four level-sensitive legacy interrupt lines (A, B, C and D) into a sticky status field. It gates that field with a software-owned enable field and drives one combined, registered interrupt request. The block uses one shared 32-bit miscellaneous word layout for both registers. Line A sits at bit 5, and lines B, C and D follow it upward, so the legacy field spans bits 8:5. Every other bit of both words reads as zero.

Software reaches the two registers over a simple register port. A write is one cycle with `wr_en` high, carrying `addr` and `wr_data`. A read is combinational: `rd_data` shows the register that `addr` selects in the same cycle.

The enable register sits at byte offset 0xB0C and the status register sits at 0xB1C. Software clears status bits by writing ones to the status register. It masks or unmasks a line by rewriting the enable register with that line's bit cleared or set. The bit for line n, with n from 1 to 4, is bit n + 4.

Top module: `lirq_ctrl`

## Requirements
- R1: While `rst_n` is low, the status field, the enable field and `irq_o` are all zero, so both registers read 0x0000_0000.
- R2: When a line input is high at a rising clock edge, its status bit reads 1 after that edge. Line A maps to bit 5, B to bit 6, C to bit 7 and D to bit 8; all four lines high read 0x1E0.
- R3: Writing to the status register at 0xB1C clears each legacy bit whose `wr_data` bit is 1, provided the line is low. A bit whose `wr_data` bit is 0 is left unchanged, and ones written outside bits 8:5 change nothing.
- R4: A status bit stays set after its line drops, until software clears it.
- R5: When a line is high in the same cycle that a clearing write hits its status bit, the bit stays 1, because setting wins over clearing.
- R6: A write to the enable register at 0xB0C loads bits 8:5 of `wr_data` into the enable field. Reading 0xB0C returns that field at bits 8:5 and zeros elsewhere; for example, writing 0xFFFF_FFFF reads back 0x1E0.
- R7: `irq_o` is the OR of (status AND enable), registered. It follows a change of either field one clock edge after the edge that changed that field.
- R8: Clearing a line's enable bit masks it. Its status bit still records the line, but that bit no longer contributes to `irq_o`.
- R9: A write to any other address changes neither register, and a read of any other address returns zero. Writes to the enable register leave the status field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 4 | Legacy interrupt lines A..D (bit 0 = A), level-sensitive, active high |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 12 | Byte address of the register being read or written |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the register selected by `addr`, combinational |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
A status bit that latches wrongly is visible on the status read in the very next cycle. If the fault is masked there, it reaches `irq_o` one edge later. An enable bit that loads from the wrong address or the wrong bit position is visible on the enable read-back. It also makes `irq_o` stay low, or rise, one edge after the write, while the status word still shows the pending line. A clear that loses to a set in the wrong order shows up as a status bit of 0 while its line is still high. A clear that leaks into an unrelated bit shows up as a status word that no longer matches the lines recorded earlier.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   localparam int unsigned LIRQ_DATA_W  = 32;
   localparam int unsigned LIRQ_ADDR_W  = 12;
   localparam int unsigned LIRQ_LINES   = 4;
   localparam int unsigned LIRQ_LSB     = 5;
   localparam int unsigned LIRQ_EN_OFS  = 32'h0000_0B0C;
   localparam int unsigned LIRQ_ST_OFS  = 32'h0000_0B1C;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_EN   = 2'd1,
      SEL_ST   = 2'd2
   } lirq_sel_e;
endpackage

// File: rtl/lirq_decode.sv
module lirq_decode
   import lirq_pkg::*;
#(
   parameter int unsigned ADDR_W = LIRQ_ADDR_W,
   parameter int unsigned EN_OFS = LIRQ_EN_OFS,
   parameter int unsigned ST_OFS = LIRQ_ST_OFS
) (
   input  logic [ADDR_W-1:0] addr,
   output lirq_sel_e         sel
);
   localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_OFS);
   localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_OFS);

   generate
      if (EN_A == ST_A) begin : g_bad_map
         $error("lirq_decode: enable and status offsets collide");
      end
      if ((ADDR_W < 32) && ((EN_OFS >> ADDR_W) != 0 || (ST_OFS >> ADDR_W) != 0)) begin : g_bad_width
         $error("lirq_decode: register offset does not fit ADDR_W");
      end
   endgenerate

   always_comb begin
      if (addr == EN_A)      sel = SEL_EN;
      else if (addr == ST_A) sel = SEL_ST;
      else                   sel = SEL_NONE;
   end
endmodule

// File: rtl/lirq_status_bit.sv
module lirq_status_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic clr_i,
   output logic st_o
);
   logic st_q;

   // a high line wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= line_i | (st_q & ~clr_i);
   end

   assign st_o = st_q;
endmodule

// File: rtl/lirq_irq_merge.sv
module lirq_irq_merge #(
   parameter int unsigned NUM_LINES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] st_i,
   input  logic [NUM_LINES-1:0] en_i,
   output logic                 irq_o
);
   logic [NUM_LINES-1:0] pend;
   logic                 irq_q;

   assign pend = st_i & en_i;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
   import lirq_pkg::*;
#(
   parameter int unsigned DATA_W    = LIRQ_DATA_W,
   parameter int unsigned ADDR_W    = LIRQ_ADDR_W,
   parameter int unsigned NUM_LINES = LIRQ_LINES,
   parameter int unsigned LINE_LSB  = LIRQ_LSB,
   parameter int unsigned EN_OFS    = LIRQ_EN_OFS,
   parameter int unsigned ST_OFS    = LIRQ_ST_OFS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_in,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 irq_o
);
   localparam int unsigned FIELD_MSB = LINE_LSB + NUM_LINES - 1;

   generate
      if (FIELD_MSB >= DATA_W) begin : g_bad_field
         $error("lirq_ctrl: legacy field exceeds DATA_W");
      end
      if (NUM_LINES == 0) begin : g_no_lines
         $error("lirq_ctrl: NUM_LINES must be non-zero");
      end
   endgenerate

   lirq_sel_e            sel;
   logic [NUM_LINES-1:0] wfield;
   logic [NUM_LINES-1:0] clr_vec;
   logic [NUM_LINES-1:0] st_q;
   logic [NUM_LINES-1:0] en_q;
   logic [NUM_LINES-1:0] rd_field;
   logic                 unused_wdata;

   assign wfield       = wr_data[LINE_LSB +: NUM_LINES];
   assign unused_wdata = ^wr_data;

   lirq_decode #(
      .ADDR_W (ADDR_W),
      .EN_OFS (EN_OFS),
      .ST_OFS (ST_OFS)
   ) u_decode (
      .addr (addr),
      .sel  (sel)
   );

   assign clr_vec = (wr_en && sel == SEL_ST) ? wfield : '0;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      lirq_status_bit u_bit (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (line_in[i]),
         .clr_i  (clr_vec[i]),
         .st_o   (st_q[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       en_q <= '0;
      else if (wr_en && sel == SEL_EN)  en_q <= wfield;
   end

   always_comb begin
      unique case (sel)
         SEL_EN:  rd_field = en_q;
         SEL_ST:  rd_field = st_q;
         default: rd_field = '0;
      endcase
      rd_data = '0;
      rd_data[LINE_LSB +: NUM_LINES] = rd_field;
   end

   lirq_irq_merge #(
      .NUM_LINES (NUM_LINES)
   ) u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .st_i  (st_q),
      .en_i  (en_q),
      .irq_o (irq_o)
   );
endmodule

// File: rtl/lirq_ctrl_chk.sv
module lirq_ctrl_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_LINES = 4,
   parameter int unsigned LINE_LSB  = 5,
   parameter int unsigned EN_OFS    = 32'h0B0C,
   parameter int unsigned ST_OFS    = 32'h0B1C
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] line_in,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    addr,
   input logic [DATA_W-1:0]    wr_data,
   input logic [NUM_LINES-1:0] st,
   input logic [NUM_LINES-1:0] en,
   input logic                 irq
);
   logic                 hit_st;
   logic                 hit_en;
   logic [NUM_LINES-1:0] wmask;
   logic                 unused_chk;

   assign hit_st     = wr_en && (addr == ADDR_W'(ST_OFS));
   assign hit_en     = wr_en && (addr == ADDR_W'(EN_OFS));
   assign wmask      = hit_st ? wr_data[LINE_LSB +: NUM_LINES] : '0;
   assign unused_chk = ^wr_data;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (st == '0 && en == '0 && !irq));

   // R2
   line_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_in != '0) |=> ((st & $past(line_in)) == $past(line_in)));

   // R3
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_st && line_in == '0) |=> ((st & $past(wmask)) == '0));

   // R4
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(st & ~wmask) & ~st) == '0));

   // R9
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_en |=> $stable(en));

   // R7
   irq_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == ($past(st & en) != '0)));
endmodule

bind lirq_ctrl lirq_ctrl_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NUM_LINES (NUM_LINES),
   .LINE_LSB  (LINE_LSB),
   .EN_OFS    (EN_OFS),
   .ST_OFS    (ST_OFS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .line_in (line_in),
   .wr_en   (wr_en),
   .addr    (addr),
   .wr_data (wr_data),
   .st      (st_q),
   .en      (en_q),
   .irq     (irq_o)
);

// File: tb/lirq_ctrl_bench.sv
module lirq_ctrl_bench;
   localparam logic [11:0] A_EN = 12'hB0C;
   localparam logic [11:0] A_ST = 12'hB1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  line_in = '0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq_o;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   always #2 clk = ~clk;

   lirq_ctrl u_lirq_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_in),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .irq_o   (irq_o)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      wr_en   = 1'b1;
      addr    = a;
      wr_data = d;
      tick();
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic check_rd(input logic [11:0] a, input logic [31:0] e, input string t);
      item_t it;
      addr = a;
      it.is_irq = 1'b0;
      it.exp = e;
      it.tag = t;
      q.push_back(it);
      tick();
   endtask

   task automatic check_irq(input logic e, input string t);
      item_t it;
      it.is_irq = 1'b1;
      it.exp = {31'd0, e};
      it.tag = t;
      q.push_back(it);
   endtask

   // monitor: samples each cycle's items 1 ns after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = it.is_irq ? {31'd0, irq_o} : rd_data;
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R1: reset state, still in reset
      check_irq(1'b0, "R1 irq in reset");
      check_rd(A_ST, 32'h0, "R1 status in reset");
      check_rd(A_EN, 32'h0, "R1 enable in reset");
      rst_n = 1'b1;

      // R2: line A sets bit 5; enable is zero so no irq (R8)
      line_in = 4'b0001;
      tick();
      check_rd(A_ST, 32'h20, "R2 line A to bit 5");
      check_irq(1'b0, "R8 irq low with enable clear");

      // R6 / R7: enable all, irq one edge later
      wr(A_EN, 32'hFFFF_FFFF);
      check_irq(1'b0, "R7 irq lags enable write");
      check_rd(A_EN, 32'h1E0, "R6 enable readback");
      check_irq(1'b1, "R7 irq after enable");

      // R3: clear with line low
      line_in = 4'b0000;
      wr(A_ST, 32'h20);
      check_irq(1'b1, "R7 irq still from old status");
      check_rd(A_ST, 32'h0, "R3 w1c clears bit 5");
      check_irq(1'b0, "R7 irq drops after clear");

      // R5: set wins over clear; R4: sticky after line drops
      line_in = 4'b0010;
      tick();
      wr(A_ST, 32'h40);
      check_rd(A_ST, 32'h40, "R5 set wins over clear");
      line_in = 4'b0000;
      check_rd(A_ST, 32'h40, "R4 sticky after line low");
      tick();
      check_rd(A_ST, 32'h40, "R4 still sticky");
      wr(A_ST, 32'h40);
      check_rd(A_ST, 32'h0, "R3 clear bit 6");

      // R3: zero writes and out-of-field ones do nothing
      line_in = 4'b1000;
      tick();
      line_in = 4'b0000;
      wr(A_ST, 32'h0);
      check_rd(A_ST, 32'h100, "R3 zero write keeps bit 8");
      wr(A_ST, 32'hFFFF_FE1F);
      check_rd(A_ST, 32'h100, "R3 out-of-field ones ignored");
      check_irq(1'b1, "R7 irq from line D");

      // R8: mask line D
      wr(A_EN, 32'h0000_00FF);
      tick();
      check_irq(1'b0, "R8 masked line gives no irq");
      check_rd(A_EN, 32'h0E0, "R8 enable bit 8 cleared");
      check_rd(A_ST, 32'h100, "R8 status still records line D");

      // R6: unmask
      wr(A_EN, 32'h0000_0100);
      tick();
      check_irq(1'b1, "R6 unmask line D raises irq");

      // R9: other address, enable writes leave status
      wr(12'h000, 32'hFFFF_FFFF);
      check_rd(A_EN, 32'h100, "R9 stray write keeps enable");
      check_rd(A_ST, 32'h100, "R9 stray write keeps status");
      check_rd(12'h000, 32'h0, "R9 other address reads zero");
      wr(A_EN, 32'h0);
      check_rd(A_ST, 32'h100, "R9 enable write keeps status");
      wr(A_ST, 32'h100);
      check_rd(A_ST, 32'h0, "R3 clear bit 8");

      // R2: all four lines
      line_in = 4'b1111;
      tick();
      check_rd(A_ST, 32'h1E0, "R2 all lines");
      line_in = 4'b0000;
      wr(A_ST, 32'h1E0);
      check_rd(A_ST, 32'h0, "R3 clear all");

      tick();
      tick();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule